// File: doc/BRIEF.md
# Register-Immediate Execute Unit

This block is the execute slice of a 64-bit RISC pipeline that handles the instructions whose second operand is a 16-bit immediate taken from the instruction word. In the instruction word the fields run, from most to least significant, as operation code [31:26], source register [25:21], destination register [20:16] and immediate [15:0]. The decoder upstream reduces the operation code to a 3-bit select. It then hands this unit the select, the value read from the source register, the immediate field and the current 32/64-bit mode.

One clock later the unit presents the destination value, a write-enable for the register file and a flag that requests an overflow exception. Each operation extends the immediate in its own way. The logical operations pad it with zeros. The adds and both compares copy its sign bit upward, and that includes the unsigned compare. The add and load-upper results are 32-bit values. In 64-bit mode they are widened by copying bit 31. In 32-bit mode only the low half of the source is read and the upper half of every result is zero.

Top module: `imm_alu_exec`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `res`, `wr_en` and `ovf_trap` are all zero.
- R2: `op_sel` encoding: 0 = add with overflow trap, 1 = add without trap, 2 = signed set-less-than, 3 = unsigned set-less-than, 4 = AND, 5 = OR, 6 = XOR, 7 = load upper. An operation presented with `in_valid` high at one rising edge shows its outputs after that edge. For the trapping add, the result is the low 32 bits of `src_val` plus the sign-extended immediate, and `wr_en` is 1 when there is no overflow.
- R3: A trapping add whose two 32-bit operands share a sign while the sum's bit 31 differs from it sets `ovf_trap` to 1 and `wr_en` to 0.
- R4: The non-trapping add yields the wrapped 32-bit sum. It never sets `ovf_trap` and always writes.
- R5: Signed set-less-than compares the source with the sign-extended immediate as two's-complement numbers. It yields 1 when the source is smaller, otherwise 0.
- R6: Unsigned set-less-than compares the source with the sign-extended immediate as unsigned numbers, so immediate 0xFFFF compares as all ones. It yields 1 or 0.
- R7: AND, OR and XOR combine the source bitwise with the immediate padded with zeros. In 64-bit mode all 64 source bits take part.
- R8: Load-upper places the immediate in result bits 31:16, clears bits 15:0 and ignores `src_val`.
- R9: In 64-bit mode (`wide_mode` = 1), add and load-upper results have bits 63:32 equal to bit 31.
- R10: In 32-bit mode (`wide_mode` = 0), only `src_val[31:0]` is used, compares are done on 32 bits, and result bits 63:32 are zero for every operation.
- R11: A cycle with `in_valid` low gives `wr_en` = 0 and `ovf_trap` = 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Decoded operation select (encoding in R2) |
| src_val | input | 64 | Source register value |
| imm | input | 16 | Immediate field of the instruction |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| res | output | 64 | Destination value |
| wr_en | output | 1 | Destination register write-enable |
| ovf_trap | output | 1 | Overflow exception request |

## Verification
The bound checker watches the structural rules on every cycle. A trap always suppresses the write, and only the trapping add can raise a trap. Idle cycles neither write nor trap. A compare result is always 0 or 1, and load-upper never sets the low half. The checker also sees that 32-bit mode leaves the upper half zero and that 64-bit add and load-upper results are sign-copied from bit 31. The arithmetic values themselves need the bench's directed scenarios. These include the sign-extended immediate in the unsigned compare, overflow in both directions, zero padding for the logical operations, and the signed compare giving opposite answers on the same source in 32-bit and 64-bit mode.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD_TRAP = 3'd0,
      OP_ADD_WRAP = 3'd1,
      OP_LT_SGN   = 3'd2,
      OP_LT_UNS   = 3'd3,
      OP_AND      = 3'd4,
      OP_OR       = 3'd5,
      OP_XOR      = 3'd6,
      OP_UPPER    = 3'd7
   } imm_op_e;
endpackage

// File: rtl/imm_ext_unit.sv
module imm_ext_unit #(
   parameter int XLEN = 64,
   parameter int IMMW = 16
) (
   input  logic [IMMW-1:0] imm_in,
   output logic [XLEN-1:0] imm_sext,
   output logic [XLEN-1:0] imm_zext
);
   localparam int PADW = XLEN - IMMW;
   always_comb begin
      imm_sext = {{PADW{imm_in[IMMW-1]}}, imm_in};
      imm_zext = {{PADW{1'b0}}, imm_in};
   end
endmodule

// File: rtl/imm_add_unit.sv
module imm_add_unit #(
   parameter int WORDW = 32
) (
   input  logic [WORDW-1:0] opa,
   input  logic [WORDW-1:0] opb,
   output logic [WORDW-1:0] sum,
   output logic             ovf
);
   always_comb begin
      sum = opa + opb;
      ovf = (opa[WORDW-1] == opb[WORDW-1]) && (sum[WORDW-1] != opa[WORDW-1]);
   end
endmodule

// File: rtl/imm_cmp_unit.sv
module imm_cmp_unit #(
   parameter int XLEN  = 64,
   parameter int WORDW = 32
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic            wide,
   input  logic            uns,
   output logic            lt
);
   logic lt_w_s, lt_w_u, lt_n_s, lt_n_u;
   always_comb begin
      lt_w_s = $signed(opa) < $signed(opb);
      lt_w_u = opa < opb;
      lt_n_s = $signed(opa[WORDW-1:0]) < $signed(opb[WORDW-1:0]);
      lt_n_u = opa[WORDW-1:0] < opb[WORDW-1:0];
      if (wide) lt = uns ? lt_w_u : lt_w_s;
      else      lt = uns ? lt_n_u : lt_n_s;
   end
endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec #(
   parameter int XLEN    = 64,
   parameter int WORDW   = 32,
   parameter int IMMW    = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [2:0]      op_sel,
   input  logic [63:0]     src_val,
   input  logic [15:0]     imm,
   input  logic            wide_mode,
   output logic [63:0]     res,
   output logic            wr_en,
   output logic            ovf_trap
);
   import imm_alu_pkg::*;

   localparam int UPW  = XLEN - WORDW;
   localparam int SHFT = WORDW - IMMW;

   if (XLEN != 64 || IMMW != 16) begin : g_bad_port
      $error("imm_alu_exec: port widths are fixed at 64/16");
   end
   if (WORDW * 2 != XLEN) begin : g_bad_word
      $error("imm_alu_exec: WORDW must be half of XLEN");
   end
   if (IMMW > WORDW) begin : g_bad_imm
      $error("imm_alu_exec: IMMW must not exceed WORDW");
   end

   imm_op_e op;
   assign op = imm_op_e'(op_sel);

   logic [XLEN-1:0]  imm_s, imm_z;
   logic [WORDW-1:0] sum32;
   logic             sum_ovf;
   logic             lt_bit;

   imm_ext_unit #(.XLEN(XLEN), .IMMW(IMMW)) u_ext (
      .imm_in   (imm),
      .imm_sext (imm_s),
      .imm_zext (imm_z)
   );

   imm_add_unit #(.WORDW(WORDW)) u_add (
      .opa (src_val[WORDW-1:0]),
      .opb (imm_s[WORDW-1:0]),
      .sum (sum32),
      .ovf (sum_ovf)
   );

   imm_cmp_unit #(.XLEN(XLEN), .WORDW(WORDW)) u_cmp (
      .opa  (src_val),
      .opb  (imm_s),
      .wide (wide_mode),
      .uns  (op == OP_LT_UNS),
      .lt   (lt_bit)
   );

   logic [WORDW-1:0] word_res;
   logic [XLEN-1:0]  full_res;
   logic [XLEN-1:0]  nxt_res;
   logic             nxt_we, nxt_trap;
   logic             is_word_op;

   always_comb begin
      word_res   = '0;
      full_res   = '0;
      is_word_op = 1'b0;
      unique case (op)
         OP_ADD_TRAP, OP_ADD_WRAP: begin
            word_res   = sum32;
            is_word_op = 1'b1;
         end
         OP_UPPER: begin
            word_res   = {imm, {SHFT{1'b0}}};
            is_word_op = 1'b1;
         end
         OP_LT_SGN, OP_LT_UNS: full_res = {{(XLEN-1){1'b0}}, lt_bit};
         OP_AND:               full_res = src_val & imm_z;
         OP_OR:                full_res = src_val | imm_z;
         OP_XOR:               full_res = src_val ^ imm_z;
         default:              full_res = '0;
      endcase
      if (is_word_op)
         nxt_res = wide_mode ? {{UPW{word_res[WORDW-1]}}, word_res}
                             : {{UPW{1'b0}}, word_res};
      else
         nxt_res = wide_mode ? full_res : {{UPW{1'b0}}, full_res[WORDW-1:0]};
      nxt_trap = in_valid && (op == OP_ADD_TRAP) && sum_ovf;
      nxt_we   = in_valid && !nxt_trap;
   end

   if (REG_OUT) begin : g_reg
      logic [XLEN-1:0] res_q;
      logic            we_q, trap_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q  <= '0;
            we_q   <= 1'b0;
            trap_q <= 1'b0;
         end else begin
            if (in_valid) res_q <= nxt_res;
            we_q   <= nxt_we;
            trap_q <= nxt_trap;
         end
      end
      assign res      = res_q;
      assign wr_en    = we_q;
      assign ovf_trap = trap_q;
   end else begin : g_comb
      assign res      = nxt_res;
      assign wr_en    = nxt_we;
      assign ovf_trap = nxt_trap;
   end
endmodule

// File: rtl/imm_alu_exec_chk.sv
module imm_alu_exec_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [2:0]  op_sel,
   input logic        wide_mode,
   input logic [63:0] res,
   input logic        wr_en,
   input logic        ovf_trap
);
   logic       q_vld, q_wide;
   logic [2:0] q_op;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_vld  <= 1'b0;
         q_wide <= 1'b0;
         q_op   <= 3'd0;
      end else begin
         q_vld  <= in_valid;
         q_wide <= wide_mode;
         q_op   <= op_sel;
      end
   end

   if (REG_OUT) begin : g_props
      // R3: a trap never writes
      p_trap_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_trap |-> !wr_en);
      // R4: only the trapping add may trap
      p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (q_vld && q_op != 3'd0) |-> !ovf_trap);
      // R11: idle cycle produces no write and no trap
      p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !q_vld |-> (!wr_en && !ovf_trap));
      // R5, R6: compare result is 0 or 1
      p_lt_binary_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (q_vld && (q_op == 3'd2 || q_op == 3'd3)) |-> (res[63:1] == '0));
      // R8: load-upper clears low half-word
      p_upper_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (q_vld && q_op == 3'd7) |-> (res[15:0] == '0));
      // R9: 64-bit add and load-upper are sign-copied from bit 31
      p_wide_sext_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (q_vld && q_wide && (q_op == 3'd0 || q_op == 3'd1 || q_op == 3'd7))
         |-> (res[63:32] == {32{res[31]}}));
      // R10: 32-bit mode clears the upper half
      p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (q_vld && !q_wide) |-> (res[63:32] == '0));
   end
endmodule

bind imm_alu_exec imm_alu_exec_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .wide_mode (wide_mode),
   .res       (res),
   .wr_en     (wr_en),
   .ovf_trap  (ovf_trap)
);

// File: tb/imm_alu_exec_bench.sv
module imm_alu_exec_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [63:0] src_val = '0;
   logic [15:0] imm = '0;
   logic        wide_mode = 1'b1;
   logic [63:0] res;
   logic        wr_en, ovf_trap;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   imm_alu_exec u_imm_alu_exec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .src_val(src_val), .imm(imm), .wide_mode(wide_mode),
      .res(res), .wr_en(wr_en), .ovf_trap(ovf_trap)
   );

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // drive one op at a falling edge, check after the next rising edge
   task automatic run_op(input string tag, input logic [2:0] op,
                         input logic [63:0] rs, input logic [15:0] im,
                         input logic wide, input bit chk_res,
                         input logic [63:0] exp_res, input logic exp_we,
                         input logic exp_trap);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; src_val = rs; imm = im; wide_mode = wide;
      @(negedge clk);
      in_valid = 1'b0;
      if (chk_res) check({tag, " res"}, res, exp_res);
      check({tag, " wr_en"}, {63'd0, wr_en}, {63'd0, exp_we});
      check({tag, " ovf_trap"}, {63'd0, ovf_trap}, {63'd0, exp_trap});
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 res", res, 64'd0);
      check("R1 wr_en", {63'd0, wr_en}, 64'd0);
      check("R1 ovf_trap", {63'd0, ovf_trap}, 64'd0);
   endtask

   task automatic t_add;
      run_op("R2 add trap", 3'd0, 64'h10, 16'hFFFF, 1'b1, 1, 64'hF, 1'b1, 1'b0);
      run_op("R3 pos ovf", 3'd0, 64'h7FFF_FFFF, 16'h0001, 1'b1, 0, 64'd0, 1'b0, 1'b1);
      run_op("R3 neg ovf", 3'd0, 64'h8000_0000, 16'h8000, 1'b1, 0, 64'd0, 1'b0, 1'b1);
      run_op("R4 R9 wrap add", 3'd1, 64'h7FFF_FFFF, 16'h0001, 1'b1, 1,
             64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
   endtask

   task automatic t_compare;
      run_op("R5 slt lt", 3'd2, 64'hFFFF_FFFF_FFFF_FFFE, 16'hFFFF, 1'b1, 1, 64'd1, 1'b1, 1'b0);
      run_op("R5 slt eq", 3'd2, 64'd5, 16'h0005, 1'b1, 1, 64'd0, 1'b1, 1'b0);
      run_op("R5 slt vs neg", 3'd2, 64'd5, 16'hFFFF, 1'b1, 1, 64'd0, 1'b1, 1'b0);
      run_op("R6 sltu sext", 3'd3, 64'd5, 16'hFFFF, 1'b1, 1, 64'd1, 1'b1, 1'b0);
      run_op("R6 sltu eq", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1'b1, 1, 64'd0, 1'b1, 1'b0);
   endtask

   task automatic t_logic;
      run_op("R7 and", 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8421, 1'b1, 1, 64'h8421, 1'b1, 1'b0);
      run_op("R7 or", 3'd5, 64'h1234_0000_0000_0000, 16'h8000, 1'b1, 1,
             64'h1234_0000_0000_8000, 1'b1, 1'b0);
      run_op("R7 xor", 3'd6, 64'hFFFF_FFFF_FFFF_0F0F, 16'hFFFF, 1'b1, 1,
             64'hFFFF_FFFF_FFFF_F0F0, 1'b1, 1'b0);
   endtask

   task automatic t_upper;
      run_op("R8 lui", 3'd7, 64'hDEAD_BEEF_CAFE_F00D, 16'h1234, 1'b1, 1,
             64'h0000_0000_1234_0000, 1'b1, 1'b0);
      run_op("R9 lui neg", 3'd7, 64'd0, 16'h8001, 1'b1, 1, 64'hFFFF_FFFF_8001_0000, 1'b1, 1'b0);
   endtask

   task automatic t_narrow;
      run_op("R10 lui", 3'd7, 64'd0, 16'h8001, 1'b0, 1, 64'h0000_0000_8001_0000, 1'b1, 1'b0);
      run_op("R10 and", 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1'b0, 1, 64'hFFFF, 1'b1, 1'b0);
      run_op("R10 xor", 3'd6, 64'hABCD_0000_0000_0000, 16'h00FF, 1'b0, 1, 64'hFF, 1'b1, 1'b0);
      run_op("R10 sltu", 3'd3, 64'hFFFF_FFFF_0000_0005, 16'hFFFF, 1'b0, 1, 64'd1, 1'b1, 1'b0);
      run_op("R10 slt", 3'd2, 64'h0000_0000_8000_0000, 16'h0000, 1'b0, 1, 64'd1, 1'b1, 1'b0);
      run_op("R10 slt wide", 3'd2, 64'h0000_0000_8000_0000, 16'h0000, 1'b1, 1, 64'd0, 1'b1, 1'b0);
      run_op("R10 add", 3'd1, 64'h0000_0001_7FFF_FFFF, 16'h0001, 1'b0, 1,
             64'h0000_0000_8000_0000, 1'b1, 1'b0);
   endtask

   task automatic t_idle;
      run_op("R11 trap first", 3'd0, 64'h7FFF_FFFF, 16'h0001, 1'b1, 0, 64'd0, 1'b0, 1'b1);
      @(negedge clk);
      check("R11 idle wr_en", {63'd0, wr_en}, 64'd0);
      check("R11 idle ovf_trap", {63'd0, ovf_trap}, 64'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {62'd0, wr_en, ovf_trap}, 64'd0);
      t_add();
      t_compare();
      t_logic();
      t_upper();
      t_narrow();
      t_idle();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule